// File: doc/BRIEF.md
# Gray-Code Reciprocal Frequency Counter

This block measures the frequency of an external square wave that has no relation to the system clock. The external signal clocks a small event counter directly. That counter keeps its value in Gray code, so a sample taken at any moment is off by at most one increment. The system clock domain passes the Gray value through a two-flop synchronizer and decodes it to binary. A gate timer running on the system clock marks the end of each measurement window. At each window end the decoded count is sampled, and the result is its modular difference from the sample taken at the previous window end.

The window length is picked by a 3-bit select input from five parameterised lengths. The defaults are 100,000, 250,000, 500,000, 1,000,000 and 10,000,000 system cycles. The output is the number of input cycles seen in one window, with a one-cycle valid strobe. After reset, or after the select moves to a different window length, the first window only primes the previous-sample register. The first result follows one window later. Turning the count into display units is left to the logic that consumes it.

Top module: `freq_meter`

## Requirements
- R1: The event counter advances by one on each rising edge of `sigIn`. The input must be slower than `sysClk`, so two successive synchronized samples differ in at most one bit, and an input that does not toggle gives a result of exactly 0.
- R2: Select codes 0, 1, 2, 3 and 4 pick windows of `GATE_0`, `GATE_1`, `GATE_2`, `GATE_3` and `GATE_4` system cycles. Codes 5, 6 and 7 act exactly like code 4, and moving among codes 4 to 7 does not restart the window.
- R3: Each result is the number of rising input edges in one window. It lies within one count of the range from floor(N·Tsys/Tsig) to ceil(N·Tsys/Tsig).
- R4: `countValid` is a one-cycle pulse. In steady state it recurs exactly once every N system cycles.
- R5: `cycleCount` changes only in the cycle in which `countValid` is high, and holds its value between pulses.
- R6: After the select moves to a code with a different window length, the first `countValid` rises 2N system clock edges after the edge that first samples the new code. The priming window yields no result.
- R7: The difference is taken modulo 2^COUNT_W. A result is correct across any number of counter wraparounds, provided fewer than 2^COUNT_W input edges fall in one window.
- R8: While `rst_n` is low, `countValid` is 0 and `cycleCount` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sysClk | input | 1 | System clock; gate timer and result logic |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| sigIn | input | 1 | Measured square wave; clocks the Gray event counter |
| gateSel | input | 3 | Window length select code |
| cycleCount | output | COUNT_W | Input cycles counted in the last window |
| countValid | output | 1 | One-cycle strobe marking a new result |

## Verification
Slow, fast and random input periods are each run against every window length. None of the periods divides evenly into the system period, so the ±1 sampling tolerance is tested rather than hidden by aligned edges. A fast input with the longest window wraps the narrowed counter within most windows, which separates a modular difference from a plain one. A stopped input must read exactly zero, which separates true edge counting from any fixed offset. Select changes are timed from the sampling edge to the first pulse, and a switch from code 4 to code 7 must neither restart the window nor change the spacing between pulses.

// File: rtl/freq_meter_pkg.sv
`timescale 1ns/1ps
package freq_meter_pkg;

  // Strobes from the gate controller to the datapath
  typedef struct packed {
    logic sample;   // window end: capture count into previous-sample register
    logic publish;  // window end with a primed previous sample: emit result
  } gate_strobe_t;

  localparam int SEL_W   = 3;
  localparam int SEL_TOP = 4;  // highest distinct select code

  function automatic int gateMax(int a, int b, int c, int d, int e);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

endpackage

// File: rtl/fm_gray_counter.sv
`timescale 1ns/1ps
module fm_gray_counter #(
  parameter int COUNT_W = 16
) (
  input  logic               sigClk,
  input  logic               rst_n,
  output logic [COUNT_W-1:0] grayOut
);

  // Local reset release, retimed into the measured-signal domain
  logic [1:0] rstPipe;
  always_ff @(posedge sigClk or negedge rst_n) begin
    if (!rst_n) rstPipe <= 2'b00;
    else        rstPipe <= {rstPipe[0], 1'b1};
  end

  logic [COUNT_W-1:0] binCnt;
  logic [COUNT_W-1:0] binNext;
  assign binNext = binCnt + 1'b1;

  always_ff @(posedge sigClk or negedge rst_n) begin
    if (!rst_n) begin
      binCnt  <= '0;
      grayOut <= '0;
    end else if (rstPipe[1]) begin
      binCnt  <= binNext;
      grayOut <= binNext ^ (binNext >> 1);
    end
  end

endmodule

// File: rtl/fm_gate_ctrl.sv
`timescale 1ns/1ps
module fm_gate_ctrl
  import freq_meter_pkg::*;
#(
  parameter int GATE_0 = 100000,
  parameter int GATE_1 = 250000,
  parameter int GATE_2 = 500000,
  parameter int GATE_3 = 1000000,
  parameter int GATE_4 = 10000000,
  parameter int LIM_W  = $clog2(gateMax(GATE_0, GATE_1, GATE_2, GATE_3, GATE_4))
) (
  input  logic             sysClk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] gateSel,
  output gate_strobe_t     strobe,
  output logic [LIM_W-1:0] gateLimit
);

  logic [SEL_W-1:0] normSel;
  logic [SEL_W-1:0] selReg;
  logic [LIM_W-1:0] gateCnt;
  logic             primed;
  logic             restart;
  logic             gateEnd;

  // codes above the top one alias to it
  assign normSel = (gateSel > SEL_W'(SEL_TOP)) ? SEL_W'(SEL_TOP) : gateSel;
  assign restart = (normSel != selReg);

  always_comb begin
    case (selReg)
      3'd0:    gateLimit = LIM_W'(GATE_0 - 1);
      3'd1:    gateLimit = LIM_W'(GATE_1 - 1);
      3'd2:    gateLimit = LIM_W'(GATE_2 - 1);
      3'd3:    gateLimit = LIM_W'(GATE_3 - 1);
      default: gateLimit = LIM_W'(GATE_4 - 1);
    endcase
  end

  assign gateEnd = (gateCnt == gateLimit);

  always_ff @(posedge sysClk or negedge rst_n) begin
    if (!rst_n) begin
      selReg  <= '0;
      gateCnt <= '0;
      primed  <= 1'b0;
    end else if (restart) begin
      selReg  <= normSel;
      gateCnt <= '0;
      primed  <= 1'b0;
    end else if (gateEnd) begin
      gateCnt <= '0;
      primed  <= 1'b1;
    end else begin
      gateCnt <= gateCnt + 1'b1;
    end
  end

  assign strobe.sample  = gateEnd && !restart;
  assign strobe.publish = gateEnd && primed && !restart;

endmodule

// File: rtl/fm_datapath.sv
`timescale 1ns/1ps
module fm_datapath
  import freq_meter_pkg::*;
#(
  parameter int COUNT_W = 16
) (
  input  logic               sysClk,
  input  logic               rst_n,
  input  logic [COUNT_W-1:0] grayIn,      // from the measured-signal domain
  input  gate_strobe_t       strobe,
  output logic [COUNT_W-1:0] graySync,
  output logic [COUNT_W-1:0] cycleCount,
  output logic               countValid
);

  logic [COUNT_W-1:0] grayMeta;
  logic [COUNT_W-1:0] binComb;
  logic [COUNT_W-1:0] binQ;
  logic [COUNT_W-1:0] prevQ;

  // two-stage synchronizer for the Gray word
  always_ff @(posedge sysClk or negedge rst_n) begin
    if (!rst_n) begin
      grayMeta <= '0;
      graySync <= '0;
    end else begin
      grayMeta <= grayIn;
      graySync <= grayMeta;
    end
  end

  // prefix XOR from the top bit down
  assign binComb[COUNT_W-1] = graySync[COUNT_W-1];
  for (genvar i = COUNT_W - 2; i >= 0; i--) begin : g_decode
    assign binComb[i] = binComb[i+1] ^ graySync[i];
  end

  always_ff @(posedge sysClk or negedge rst_n) begin
    if (!rst_n) begin
      binQ       <= '0;
      prevQ      <= '0;
      cycleCount <= '0;
      countValid <= 1'b0;
    end else begin
      binQ       <= binComb;
      countValid <= strobe.publish;
      if (strobe.sample)  prevQ      <= binQ;
      if (strobe.publish) cycleCount <= binQ - prevQ;  // modulo 2^COUNT_W
    end
  end

endmodule

// File: rtl/freq_meter.sv
`timescale 1ns/1ps
module freq_meter
  import freq_meter_pkg::*;
#(
  parameter int COUNT_W = 16,
  parameter int GATE_0  = 100000,
  parameter int GATE_1  = 250000,
  parameter int GATE_2  = 500000,
  parameter int GATE_3  = 1000000,
  parameter int GATE_4  = 10000000
) (
  input  logic               sysClk,
  input  logic               rst_n,
  input  logic               sigIn,
  input  logic [2:0]         gateSel,
  output logic [COUNT_W-1:0] cycleCount,
  output logic               countValid
);

  localparam int LIM_W = $clog2(gateMax(GATE_0, GATE_1, GATE_2, GATE_3, GATE_4));

  logic [COUNT_W-1:0] grayCnt;
  logic [LIM_W-1:0]   gateLimit;
  gate_strobe_t       strobe;

  fm_gray_counter #(.COUNT_W(COUNT_W)) u_cnt (
    .sigClk (sigIn),
    .rst_n  (rst_n),
    .grayOut(grayCnt)
  );

  fm_gate_ctrl #(
    .GATE_0(GATE_0), .GATE_1(GATE_1), .GATE_2(GATE_2),
    .GATE_3(GATE_3), .GATE_4(GATE_4), .LIM_W(LIM_W)
  ) u_ctl (
    .sysClk   (sysClk),
    .rst_n    (rst_n),
    .gateSel  (gateSel),
    .strobe   (strobe),
    .gateLimit(gateLimit)
  );

  logic [COUNT_W-1:0] graySync;

  fm_datapath #(.COUNT_W(COUNT_W)) u_dp (
    .sysClk    (sysClk),
    .rst_n     (rst_n),
    .grayIn    (grayCnt),
    .strobe    (strobe),
    .graySync  (graySync),
    .cycleCount(cycleCount),
    .countValid(countValid)
  );

endmodule

// File: rtl/fm_checker.sv
`timescale 1ns/1ps
module fm_checker #(
  parameter int COUNT_W = 16,
  parameter int LIM_W   = 24
) (
  input logic               sysClk,
  input logic               rst_n,
  input logic [COUNT_W-1:0] syncGray,
  input logic [LIM_W-1:0]   gateLimit,
  input logic [COUNT_W-1:0] cycleCount,
  input logic               countValid
);

  logic [LIM_W-1:0] lastLimit;
  logic [LIM_W+1:0] sinceStart;
  logic [LIM_W+1:0] gapCnt;
  logic             hadValid;
  logic             limChange;

  assign limChange = (gateLimit != lastLimit);

  always_ff @(posedge sysClk or negedge rst_n) begin
    if (!rst_n) begin
      lastLimit  <= '0;
      sinceStart <= '0;
      gapCnt     <= '0;
      hadValid   <= 1'b0;
    end else begin
      lastLimit <= gateLimit;
      if (limChange) sinceStart <= '0;
      else if (sinceStart != '1) sinceStart <= sinceStart + 1'b1;
      if (countValid) gapCnt <= (LIM_W+2)'(1);
      else if (gapCnt != '1) gapCnt <= gapCnt + 1'b1;
      if (limChange) hadValid <= 1'b0;
      else if (countValid) hadValid <= 1'b1;
    end
  end

  // R1: synchronized Gray word moves by at most one bit per sample
  a_r1_gray_one_step: assert property (@(posedge sysClk) disable iff (!rst_n)
    $countones(syncGray ^ $past(syncGray)) <= 1);

  // R4: strobe lasts a single cycle
  a_r4_single_pulse: assert property (@(posedge sysClk) disable iff (!rst_n)
    countValid |=> !countValid);

  // R4: steady-state spacing equals the window length
  a_r4_valid_spacing: assert property (@(posedge sysClk) disable iff (!rst_n)
    (countValid && hadValid && !limChange) |-> (gapCnt == (LIM_W+2)'(gateLimit) + 1'b1));

  // R5: result moves only together with the strobe
  a_r5_hold: assert property (@(posedge sysClk) disable iff (!rst_n)
    !$stable(cycleCount) |-> countValid);

  // R6: no result before a full priming window has passed
  a_r6_primed: assert property (@(posedge sysClk) disable iff (!rst_n)
    countValid |-> (sinceStart > (LIM_W+2)'(gateLimit)));

  // R8: quiet outputs during reset
  a_r8_reset_quiet: assert property (@(posedge sysClk)
    !rst_n |-> (!countValid && cycleCount == '0));

endmodule

bind freq_meter fm_checker #(.COUNT_W(COUNT_W), .LIM_W(LIM_W)) chk (
  .sysClk    (sysClk),
  .rst_n     (rst_n),
  .syncGray  (u_dp.graySync),
  .gateLimit (gateLimit),
  .cycleCount(cycleCount),
  .countValid(countValid)
);

// File: tb/freq_meter_test.sv
`timescale 1ns/1ps
module freq_meter_test;

  localparam int CW = 10;
  localparam int G0 = 40, G1 = 100, G2 = 200, G3 = 500, G4 = 1000;
  localparam realtime TSYS = 8.0;

  logic          sysClk = 1'b0;
  logic          rst_n  = 1'b0;
  logic          sigIn  = 1'b0;
  logic [2:0]    gateSel = 3'd0;
  logic [CW-1:0] cycleCount;
  logic          countValid;

  int      checks = 0;
  int      errors = 0;
  bit      done   = 0;
  bit      sigRun = 1;
  realtime halfPer = 6.35;
  int      curNorm = 0;

  freq_meter #(.COUNT_W(CW), .GATE_0(G0), .GATE_1(G1), .GATE_2(G2),
               .GATE_3(G3), .GATE_4(G4)) uut (
    .sysClk(sysClk), .rst_n(rst_n), .sigIn(sigIn), .gateSel(gateSel),
    .cycleCount(cycleCount), .countValid(countValid));

  always #(TSYS/2) sysClk = ~sysClk;

  initial forever begin
    #(halfPer);
    if (sigRun) sigIn = ~sigIn;
  end

  function automatic int gateLen(int code);
    case (code)
      0: return G0;
      1: return G1;
      2: return G2;
      3: return G3;
      default: return G4;
    endcase
  endfunction

  function automatic int normCode(int code);
    return (code > 4) ? 4 : code;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // wait for next strobe; report cycles waited and whether the result moved in between
  task automatic waitValid(output int gap, output bit moved);
    logic [CW-1:0] held;
    held  = cycleCount;
    gap   = 0;
    moved = 0;
    do begin
      @(posedge sysClk);
      gap++;
      @(negedge sysClk);
      if (!countValid && cycleCount != held) moved = 1;
    end while (!countValid);
  endtask

  task automatic changeSel(int code);
    int n, k;
    @(negedge sysClk);
    gateSel = code[2:0];
    if (normCode(code) != curNorm) begin
      curNorm = normCode(code);
      n = gateLen(code);
      @(posedge sysClk);
      k = 0;
      do begin
        @(posedge sysClk);
        k++;
        @(negedge sysClk);
      end while (!countValid);
      // R6: first result 2N edges after the sampling edge
      check(k == 2 * n, "R6", "cycles to first result", k, 2 * n);
    end
  endtask

  // discard one result, then check nGates results against the ideal ratio
  task automatic measure(int nGates, realtime per, bit idle);
    int gap;
    bit moved;
    int n;
    real r;
    longint lo, hi;
    n = gateLen(curNorm);
    waitValid(gap, moved);
    for (int i = 0; i < nGates; i++) begin
      waitValid(gap, moved);
      check(gap == n, "R4", "strobe spacing", gap, n);
      check(!moved, "R5", "result moved between strobes", moved, 0);
      if (idle) begin
        check(cycleCount == 0, "R1", "count with stopped input", cycleCount, 0);
      end else begin
        r  = n * TSYS / per;
        lo = longint'($floor(r)) - 1;
        hi = longint'($ceil(r)) + 1;
        // R3 and R7: result within one of the ideal count, across counter wraps
        check(cycleCount >= lo && cycleCount <= hi, "R3/R7", "window count",
              cycleCount, longint'($floor(r + 0.5)));
      end
    end
  endtask

  task automatic setPer(realtime per);
    halfPer = per / 2.0;
  endtask

  initial begin
    int dummy;
    int gap;
    bit moved;
    dummy = $urandom(32'h5EED);
    setPer(12.7);
    repeat (5) @(posedge sysClk);
    @(negedge sysClk);
    // R8: quiet during reset
    check(countValid == 1'b0, "R8", "valid in reset", countValid, 0);
    check(cycleCount == 0, "R8", "count in reset", cycleCount, 0);
    rst_n = 1'b1;

    // code 1, slow input (R2 via spacing, R6 latency)
    setPer(23.3);
    changeSel(1);
    measure(3, 23.3, 0);

    // code 0, fast input
    setPer(10.9);
    changeSel(0);
    measure(3, 10.9, 0);

    // code 4, fast input: counter wraps in most windows (R7)
    setPer(10.3);
    changeSel(4);
    measure(4, 10.3, 0);

    // code 7 aliases code 4: no restart, same spacing (R2)
    @(negedge sysClk);
    gateSel = 3'd7;
    waitValid(gap, moved);
    check(gap <= G4, "R2", "code 7 restarted window", gap, G4);
    measure(2, 10.3, 0);
    curNorm = 4;

    // stopped input reads exactly zero (R1)
    changeSel(2);
    sigRun = 0;
    measure(2, 10.0, 1);
    sigRun = 1;

    // code 3 at a mid period
    setPer(17.77);
    changeSel(3);
    measure(2, 17.77, 0);

    // random mix
    for (int it = 0; it < 8; it++) begin
      int code;
      realtime per;
      code = int'($urandom % 8);
      per  = 10.0 + real'($urandom % 5000) / 100.0 + 0.013;
      setPer(per);
      changeSel(code);
      measure(2, per, 0);
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge sysClk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule